// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged control registers of a processor core. Each register has a small index. A read port returns a register combinationally in the same cycle. A write port updates the addressed register at the next clock edge.

Writes do not simply store the data. Each register applies its own rule:

- Some registers keep only selected bits.
- Some registers clear on any write.
- One register latches a constant on any write.
- Some indices are control actions. They do not store data. Instead they emit a one-cycle flush strobe toward the translation buffers.

A free-running 32-bit cycle counter supplies the low half of the cycle register whenever that register is read. An illegal access raises a one-cycle error flag:

- a read of a write-only index,
- a write of a read-only index, or
- any access to an index outside the map.

Top module: `ctl_reg_bank`

## Requirements
- R1: After reset every stored register reads zero, except three. Index 9 (misc control) reads 0x6. Index 8 (vector base) reads parameter BASE_INIT. Index 26 (cycle) reads live counter bits in its low half.
- R2: Writes are masked per index. Index 11 and 12 keep bits 3:0. Index 13 keeps bits 4:0. Index 14 and 15 keep bits 4:3. Index 16 keeps mask 0x7fff0. Index 17 keeps 0xffffff0300. Index 18 keeps 0xffffffffc0000000. Index 19 keeps 0x1ffb. Index 20 and 21 keep 0x3f. Index 22 keeps 0x7f0. Index 23 keeps bits 63:57.
- R3: A write to index 10 (exception PC) stores the data with bit 1 forced to zero.
- R4: Any write to index 24 or index 25 clears that register to zero, whatever the data.
- R5: A read of index 26 returns the stored bits 63:32 above the live counter. The live counter is zero in reset and increments on every clock edge out of reset.
- R6: Any write to index 27 sets that register to 1.
- R7: Writes to indices 30 and 31 pulse a flush strobe for the instruction side (all entries, process entries). Writes to 33 and 34 do the same for the data side. Each strobe is high for exactly the one cycle after the write edge.
- R8: A write to index 32 pulses the single-entry instruction flush, with flush_addr equal to the written data and flush_asn equal to bits 10:4 of index 22. A write to index 35 does the same on the data side, with flush_asn equal to bits 63:57 of index 23.
- R9: acc_err is high for the one cycle after an edge that saw a read of index 30 or above, or a write of index 28, 29 or 36 and above. A faulting read returns zero data.
- R10: A faulting write changes no register. Read-only indices 28 and 29 keep reading zero.
- R11: Indices 0 to 9 store and return all 64 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Read index |
| rd_data | output | 64 | Read data, same cycle |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Write index |
| wr_data | input | 64 | Write data |
| acc_err | output | 1 | One-cycle access error flag |
| iflush_all | output | 1 | Instruction-side flush of all entries |
| iflush_proc | output | 1 | Instruction-side flush of process entries |
| iflush_one | output | 1 | Instruction-side single-entry flush |
| dflush_all | output | 1 | Data-side flush of all entries |
| dflush_proc | output | 1 | Data-side flush of process entries |
| dflush_one | output | 1 | Data-side single-entry flush |
| flush_addr | output | 64 | Address for a single-entry flush |
| flush_asn | output | 7 | Address-space number for a single-entry flush |

## Verification
The hardest case is a single-entry flush that carries a non-trivial address-space number. Reaching it takes a masked write to the ASN register followed by a write to the flush index, and the strobe is only visible one cycle later.

The random stream draws indices over the whole map, so ASN writes and flush writes interleave freely. Directed sequences then pin the case down with known ASN values. The cycle-register merge is checked against a bench-side edge counter at arbitrary points in the run.

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
  parameter logic [63:0] BASE_INIT = 64'h0000_0000_0040_0000,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  output logic             acc_err,
  output logic             iflush_all,
  output logic             iflush_proc,
  output logic             iflush_one,
  output logic             dflush_all,
  output logic             dflush_proc,
  output logic             dflush_one,
  output logic [63:0]      flush_addr,
  output logic [6:0]       flush_asn
);

  localparam int NSLOT = 32;
  localparam logic [IDX_W-1:0] I_BASE   = IDX_W'(8);
  localparam logic [IDX_W-1:0] I_MISC   = IDX_W'(9);
  localparam logic [IDX_W-1:0] I_EPC    = IDX_W'(10);
  localparam logic [IDX_W-1:0] I_TREQ   = IDX_W'(11);
  localparam logic [IDX_W-1:0] I_TEN    = IDX_W'(12);
  localparam logic [IDX_W-1:0] I_PRIO   = IDX_W'(13);
  localparam logic [IDX_W-1:0] I_IMODE  = IDX_W'(14);
  localparam logic [IDX_W-1:0] I_DMODE  = IDX_W'(15);
  localparam logic [IDX_W-1:0] I_SWREQ  = IDX_W'(16);
  localparam logic [IDX_W-1:0] I_ICTL   = IDX_W'(17);
  localparam logic [IDX_W-1:0] I_PTB    = IDX_W'(18);
  localparam logic [IDX_W-1:0] I_CTEST  = IDX_W'(19);
  localparam logic [IDX_W-1:0] I_CMODE  = IDX_W'(20);
  localparam logic [IDX_W-1:0] I_MBMODE = IDX_W'(21);
  localparam logic [IDX_W-1:0] I_IASN   = IDX_W'(22);
  localparam logic [IDX_W-1:0] I_DASN   = IDX_W'(23);
  localparam logic [IDX_W-1:0] I_XSUM   = IDX_W'(24);
  localparam logic [IDX_W-1:0] I_XMSK   = IDX_W'(25);
  localparam logic [IDX_W-1:0] I_CYC    = IDX_W'(26);
  localparam logic [IDX_W-1:0] I_CYCCTL = IDX_W'(27);
  localparam logic [IDX_W-1:0] I_RO0    = IDX_W'(28);
  localparam logic [IDX_W-1:0] I_RDLIM  = IDX_W'(30);
  localparam logic [IDX_W-1:0] I_IFA    = IDX_W'(30);
  localparam logic [IDX_W-1:0] I_IFP    = IDX_W'(31);
  localparam logic [IDX_W-1:0] I_IFO    = IDX_W'(32);
  localparam logic [IDX_W-1:0] I_DFA    = IDX_W'(33);
  localparam logic [IDX_W-1:0] I_DFP    = IDX_W'(34);
  localparam logic [IDX_W-1:0] I_DFO    = IDX_W'(35);
  localparam logic [IDX_W-1:0] I_END    = IDX_W'(36);

  logic [63:0] regs [NSLOT];
  logic [31:0] live;

  function automatic logic [63:0] keep_mask(input logic [IDX_W-1:0] i);
    case (i)
      I_EPC:            keep_mask = ~64'h2;
      I_TREQ, I_TEN:    keep_mask = 64'hf;
      I_PRIO:           keep_mask = 64'h1f;
      I_IMODE, I_DMODE: keep_mask = 64'h18;
      I_SWREQ:          keep_mask = 64'h7fff0;
      I_ICTL:           keep_mask = 64'hff_ffff_0300;
      I_PTB:            keep_mask = 64'hffff_ffff_c000_0000;
      I_CTEST:          keep_mask = 64'h1ffb;
      I_CMODE, I_MBMODE: keep_mask = 64'h3f;
      I_IASN:           keep_mask = 64'h7f0;
      I_DASN:           keep_mask = 64'hfe00_0000_0000_0000;
      default:          keep_mask = '1;
    endcase
  endfunction

  wire rd_ok    = rd_idx < I_RDLIM;
  wire wr_store = wr_idx < I_RO0;
  wire wr_ctl   = (wr_idx >= I_IFA) && (wr_idx < I_END);
  wire rd_fault = rd_en && !rd_ok;
  wire wr_fault = wr_en && !wr_store && !wr_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) live <= '0;
    else        live <= live + 32'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++)
        regs[i] <= (i == int'(I_MISC)) ? 64'h6 :
                   (i == int'(I_BASE)) ? BASE_INIT : 64'h0;
    end else if (wr_en && wr_store) begin
      case (wr_idx)
        I_XSUM, I_XMSK: regs[wr_idx[4:0]] <= 64'h0;
        I_CYCCTL:       regs[wr_idx[4:0]] <= 64'h1;
        default:        regs[wr_idx[4:0]] <= wr_data & keep_mask(wr_idx);
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en && rd_ok) begin
      if (rd_idx == I_CYC) rd_data = {regs[I_CYC[4:0]][63:32], live};
      else                 rd_data = regs[rd_idx[4:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_err     <= 1'b0;
      iflush_all  <= 1'b0;
      iflush_proc <= 1'b0;
      iflush_one  <= 1'b0;
      dflush_all  <= 1'b0;
      dflush_proc <= 1'b0;
      dflush_one  <= 1'b0;
      flush_addr  <= '0;
      flush_asn   <= '0;
    end else begin
      acc_err     <= rd_fault || wr_fault;
      iflush_all  <= wr_en && (wr_idx == I_IFA);
      iflush_proc <= wr_en && (wr_idx == I_IFP);
      iflush_one  <= wr_en && (wr_idx == I_IFO);
      dflush_all  <= wr_en && (wr_idx == I_DFA);
      dflush_proc <= wr_en && (wr_idx == I_DFP);
      dflush_one  <= wr_en && (wr_idx == I_DFO);
      if (wr_en && wr_idx == I_IFO) begin
        flush_addr <= wr_data;
        flush_asn  <= regs[I_IASN[4:0]][10:4];
      end else if (wr_en && wr_idx == I_DFO) begin
        flush_addr <= wr_data;
        flush_asn  <= regs[I_DASN[4:0]][63:57];
      end else begin
        flush_addr <= '0;
        flush_asn  <= '0;
      end
    end
  end

  assert_epc_bit1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == I_EPC) |=> !regs[I_EPC[4:0]][1]);

  assert_clear_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == I_XSUM) |=> (regs[I_XSUM[4:0]] == 64'h0));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iflush_all, iflush_proc, iflush_one, dflush_all, dflush_proc, dflush_one}));

  assert_iasn_carried_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == I_IFO) |=> (flush_asn == $past(regs[I_IASN[4:0]][10:4])));

  assert_bad_index_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= I_END) |=> acc_err);

  assert_ro_untouched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == I_RO0) |=> $stable(regs[I_RO0[4:0]]));

endmodule

// File: tb/ctl_reg_bank_bench.sv
module ctl_reg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] BASE = 64'h0000_0000_0040_0000;

  logic clk = 0, rst_n = 0;
  logic rd_en = 0, wr_en = 0;
  logic [5:0] rd_idx = 0, wr_idx = 0;
  logic [63:0] wr_data = 0, rd_data, flush_addr;
  logic acc_err, iflush_all, iflush_proc, iflush_one, dflush_all, dflush_proc, dflush_one;
  logic [6:0] flush_asn;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] live_cnt;
  logic [63:0] mdl [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) live_cnt <= 0;
    else        live_cnt <= live_cnt + 1;
  end

  ctl_reg_bank #(.BASE_INIT(BASE), .IDX_W(6)) u_ctl_reg_bank (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .acc_err(acc_err),
    .iflush_all(iflush_all), .iflush_proc(iflush_proc), .iflush_one(iflush_one),
    .dflush_all(dflush_all), .dflush_proc(dflush_proc), .dflush_one(dflush_one),
    .flush_addr(flush_addr), .flush_asn(flush_asn));

  function automatic logic [63:0] next_val(input int i, input logic [63:0] d, input logic [63:0] old);
    case (i)
      10: return d & ~64'h2;
      11, 12: return d & 64'hf;
      13: return d & 64'h1f;
      14, 15: return d & 64'h18;
      16: return d & 64'h7fff0;
      17: return d & 64'hff_ffff_0300;
      18: return d & 64'hffff_ffff_c000_0000;
      19: return d & 64'h1ffb;
      20, 21: return d & 64'h3f;
      22: return d & 64'h7f0;
      23: return d & 64'hfe00_0000_0000_0000;
      24, 25: return 64'h0;
      27: return 64'h1;
      28, 29: return old;
      default: return (i < 28) ? d : old;
    endcase
  endfunction

  function automatic string tag_of(input int i);
    if (i < 10) return "R11";
    if (i == 10) return "R3";
    if (i == 24 || i == 25) return "R4";
    if (i == 26) return "R5";
    if (i == 27) return "R6";
    if (i == 28 || i == 29) return "R10";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input int i);
    logic [63:0] exp;
    rd_en = 1; rd_idx = 6'(i); wr_en = 0;
    #1;
    if (i >= 30) exp = 0;
    else if (i == 26) exp = {mdl[26][63:32], live_cnt};
    else exp = mdl[i];
    check((i >= 30) ? "R9" : tag_of(i), rd_data, exp);
    @(posedge clk); @(negedge clk);
    rd_en = 0;
    check("R9", {63'b0, acc_err}, {63'b0, i >= 30});
  endtask

  task automatic do_write(input int i, input logic [63:0] d);
    logic [5:0] strb;
    logic [6:0] asn;
    wr_en = 1; wr_idx = 6'(i); wr_data = d; rd_en = 0;
    asn = (i == 32) ? mdl[22][10:4] : (i == 35) ? mdl[23][63:57] : 7'h0;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    if (i < 32) mdl[i] = next_val(i, d, mdl[i]);
    strb = {i == 30, i == 31, i == 32, i == 33, i == 34, i == 35};
    check("R9", {63'b0, acc_err}, {63'b0, (i == 28 || i == 29 || i >= 36)});
    check("R7", {58'b0, iflush_all, iflush_proc, iflush_one, dflush_all, dflush_proc, dflush_one},
          {58'b0, strb});
    if (i == 32 || i == 35) begin
      check("R8", flush_addr, d);
      check("R8", {57'b0, flush_asn}, {57'b0, asn});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 32; i++) mdl[i] = 0;
    mdl[8] = BASE; mdl[9] = 64'h6;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 30; i++) begin
      rd_en = 1; rd_idx = 6'(i); #1;
      check("R1", rd_data, (i == 26) ? {32'h0, live_cnt} : mdl[i]);
      rd_en = 0;
    end
    check("R1", {63'b0, acc_err}, 64'h0);
    // directed
    do_write(3, 64'hdead_beef_0123_4567); do_read(3);
    do_write(10, '1); do_read(10);
    do_write(24, 64'h1234); do_read(24);
    do_write(25, '1); do_read(25);
    do_write(26, 64'habcd_0000_ffff_ffff); repeat (5) @(negedge clk); do_read(26);
    do_write(27, 64'h0); do_read(27);
    do_write(13, '1); do_read(13);
    do_write(23, '1); do_read(23);
    do_write(22, 64'h5a0); do_write(32, 64'h1000_2000);
    do_write(35, 64'h3000); do_write(30, 1); do_write(34, 7);
    do_write(28, '1); do_read(28);
    do_write(63, '1); do_read(40); do_read(31);
    // random
    for (int n = 0; n < 600; n++) begin
      int i;
      i = $urandom_range(0, 40);
      if ($urandom_range(0, 1) == 1) do_write(i, {$urandom, $urandom});
      else do_read(i);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule